// File: doc/BRIEF.md
# Parallel Display Bus Master (8-bit, strobed)

This block connects a simple host request port to an 8-bit parallel display panel that uses separate write and read strobes. The host offers one transfer at a time: a flag choosing command or data, a flag choosing read or write, and a byte to write. The block then runs the panel-side handshake and reports completion with a one-cycle done pulse. For reads, it also presents the byte it captured from the panel.

The panel side has an active-low chip select and a register-select line. It also has active-low write and read strobes, an active-low panel reset and a bidirectional 8-bit data bus. The length of the strobe's low phase and of its high phase is set in clock cycles by four timing inputs, with separate values for writes and for reads. This lets a slow panel read coexist with fast writes without any reprogramming. A separate request produces a panel reset pulse of programmable length.

Top module: `parbus_disp_master`

## Requirements
- R1: The register-select output is 0 for a command transfer (req_is_data=0) and 1 for a data transfer (req_is_data=1). It holds that value for the whole time chip select is low.
- R2: A transfer runs in a fixed order. In the first cycle after acceptance, register-select is valid and chip select is still high. Chip select goes low in the second cycle, and the strobe goes low in the third cycle. Only the strobe matching the direction ever pulses: the write strobe for req_is_read=0 and the read strobe for req_is_read=1.
- R3: On a write, the block drives the byte on the data bus from the cycle after acceptance until chip select rises. The byte is therefore stable across the rising edge of the write strobe, and the panel latches exactly that byte.
- R4: On a read, the block samples the data bus at the clock edge on which the read strobe rises. It does not drive the bus during a read. The captured byte appears on rd_data and stays there unchanged through later writes until the next read.
- R5: The strobe stays low for the low count and then high, with chip select still low, for the high count. Writes use wr_lo/wr_hi and reads use rd_lo/rd_hi. A count of 0 acts as 1.
- R6: Timing counts are taken when a request is accepted. Changing them during a transfer has no effect on that transfer.
- R7: busy is high from the cycle after acceptance until the transfer ends. done is a single-cycle pulse that appears 2+L+H cycles after the accepting edge, where L and H are the effective counts. Chip select is high whenever the block is idle.
- R8: A request raised while busy is high is dropped; no second transfer is started.
- R9: A reset request taken while idle drives the panel reset low for exactly N cycles, where N is rst_len and 0 acts as 1. The reset is released in the cycle in which done pulses. busy is high for the whole pulse.
- R10: When a reset request and a transfer request arrive in the same idle cycle, the reset runs and the transfer request is dropped.
- R11: After the block's own reset, chip select, both strobes and the panel reset are high, register-select is 1, busy and done are 0, and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, taken when busy is low |
| req_is_data | input | 1 | 1 = data transfer, 0 = command transfer |
| req_is_read | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 8 | Byte to write |
| wr_lo | input | 4 | Write strobe low-phase cycles |
| wr_hi | input | 4 | Write strobe high-phase cycles |
| rd_lo | input | 4 | Read strobe low-phase cycles |
| rd_hi | input | 4 | Read strobe high-phase cycles |
| rst_req | input | 1 | Panel reset request, taken when busy is low |
| rst_len | input | 16 | Panel reset low cycles |
| busy | output | 1 | Transfer or reset pulse in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read from the panel |
| pnl_cs_n | output | 1 | Chip select, active low |
| pnl_rs | output | 1 | Register select: 0 command, 1 data |
| pnl_wr_n | output | 1 | Write strobe, active low |
| pnl_rd_n | output | 1 | Read strobe, active low |
| pnl_rst_n | output | 1 | Panel reset, active low |
| pnl_db | inout | 8 | Panel data bus |

## Verification
Counting the accepting edge as edge 0, the bench expects the following. Register-select is valid one cycle after it, chip select falls after edge 1 and the strobe falls after edge 2. done and the rising of chip select follow edge 2+L+H, and the read byte is loaded at edge 2+L. A reset pulse releases after edge N. The bench drives every input on the falling clock edge and samples every output on the falling edge, counting cycles from the acceptance. It compares the cycle in which each event shows up with these sums, which are computed from the clamped counts and never taken from the design. Write bytes are also checked by a panel model that latches the bus on the rising write strobe.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic [2:0] {
    XS_IDLE,
    XS_SETUP,
    XS_SEL,
    XS_LOW,
    XS_HIGH
  } xfer_state_e;
endpackage

// File: rtl/pdm_xfer_seq.sv
module pdm_xfer_seq
  import pdm_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_is_data,
  input  logic          start_is_read,
  input  logic [DW-1:0] start_wdata,
  input  logic [CW-1:0] wr_lo,
  input  logic [CW-1:0] wr_hi,
  input  logic [CW-1:0] rd_lo,
  input  logic [CW-1:0] rd_hi,
  output logic          busy,
  output logic          done,
  output logic          cs_n,
  output logic          rs,
  output logic          wr_n,
  output logic          rd_n,
  output logic          drv_en,
  output logic [DW-1:0] wdata,
  output logic          cap_en
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  xfer_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lo_q, hi_q;
  logic [CW-1:0] lo_sel, hi_sel, lo_eff, hi_eff;
  logic          rs_q, rd_q, done_q, done_d, load;
  logic [DW-1:0] wdata_q;

  // timing chosen by direction, zero counts clamped to one
  always_comb begin
    lo_sel = start_is_read ? rd_lo : wr_lo;
    hi_sel = start_is_read ? rd_hi : wr_hi;
    lo_eff = (lo_sel == '0) ? ONE : lo_sel;
    hi_eff = (hi_sel == '0) ? ONE : hi_sel;
  end

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load    = 1'b0;
    case (state_q)
      XS_IDLE: begin
        if (start) begin
          state_d = XS_SETUP;
          load    = 1'b1;
        end
      end
      XS_SETUP: state_d = XS_SEL;
      XS_SEL: begin
        state_d = XS_LOW;
        cnt_d   = lo_q - ONE;
      end
      XS_LOW: begin
        if (cnt_q == '0) begin
          state_d = XS_HIGH;
          cnt_d   = hi_q - ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      XS_HIGH: begin
        if (cnt_q == '0) begin
          state_d = XS_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      rs_q    <= 1'b1;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      lo_q    <= ONE;
      hi_q    <= ONE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      if (load) begin
        rs_q    <= start_is_data;
        rd_q    <= start_is_read;
        wdata_q <= start_wdata;
        lo_q    <= lo_eff;
        hi_q    <= hi_eff;
      end
    end
  end

  // output decode
  always_comb begin
    cs_n   = !((state_q == XS_SEL) || (state_q == XS_LOW) || (state_q == XS_HIGH));
    wr_n   = !((state_q == XS_LOW) && !rd_q);
    rd_n   = !((state_q == XS_LOW) && rd_q);
    drv_en = (state_q != XS_IDLE) && !rd_q;
    cap_en = (state_q == XS_LOW) && (cnt_q == '0) && rd_q;
    busy   = (state_q != XS_IDLE);
    done   = done_q;
    rs     = rs_q;
    wdata  = wdata_q;
  end

  AST_STROBE_FOLLOWS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> (!wr_n || !rd_n)); // R2
  AST_RS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(rs)); // R1
  AST_CAPTURE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> $rose(rd_n)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_ENDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n))); // R7
endmodule

// File: rtl/pdm_rst_pulse.sv
module pdm_rst_pulse #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] len,
  output logic          busy,
  output logic          done,
  output logic          pnl_rst_n
);
  localparam logic [RW-1:0] ONE = {{(RW-1){1'b0}}, 1'b1};

  logic          act_q, act_d, done_q, done_d;
  logic [RW-1:0] cnt_q, cnt_d, len_eff;

  always_comb begin
    len_eff = (len == '0) ? ONE : len;
    act_d   = act_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        cnt_d = len_eff - ONE;
      end
    end else if (cnt_q == '0) begin
      act_d  = 1'b0;
      done_d = 1'b1;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy      = act_q;
  assign done      = done_q;
  assign pnl_rst_n = !act_q;

  AST_RST_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pnl_rst_n) |-> done); // R9
  AST_RST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !act_q) |=> !pnl_rst_n); // R9
endmodule

// File: rtl/pdm_bus_io.sv
module pdm_bus_io #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drv_en,
  input  logic [DW-1:0] wdata,
  input  logic          cap_en,
  input  logic          wr_n,
  inout  wire  [DW-1:0] db,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] rd_q;

  assign db = drv_en ? wdata : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap_en) begin
      rd_q <= db;
    end
  end

  assign rd_data = rd_q;

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (drv_en && $stable(wdata))); // R3
  AST_NO_DRIVE_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> !drv_en); // R4
endmodule

// File: rtl/parbus_disp_master.sv
module parbus_disp_master #(
  parameter int DATA_W   = 8,
  parameter int TIME_W   = 4,
  parameter int RSTLEN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_is_data,
  input  logic                req_is_read,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [TIME_W-1:0]   wr_lo,
  input  logic [TIME_W-1:0]   wr_hi,
  input  logic [TIME_W-1:0]   rd_lo,
  input  logic [TIME_W-1:0]   rd_hi,
  input  logic                rst_req,
  input  logic [RSTLEN_W-1:0] rst_len,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rd_data,
  output logic                pnl_cs_n,
  output logic                pnl_rs,
  output logic                pnl_wr_n,
  output logic                pnl_rd_n,
  output logic                pnl_rst_n,
  inout  wire  [DATA_W-1:0]   pnl_db
);
  logic              x_busy, x_done, x_start, x_drv, x_cap;
  logic              r_busy, r_done, r_start;
  logic [DATA_W-1:0] x_wdata;

  // reset request wins over a transfer request in the same idle cycle
  assign r_start = rst_req && !busy;
  assign x_start = req_valid && !rst_req && !busy;
  assign busy    = x_busy || r_busy;
  assign done    = x_done || r_done;

  pdm_xfer_seq #(.DW(DATA_W), .CW(TIME_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (x_start),
    .start_is_data (req_is_data),
    .start_is_read (req_is_read),
    .start_wdata   (req_wdata),
    .wr_lo         (wr_lo),
    .wr_hi         (wr_hi),
    .rd_lo         (rd_lo),
    .rd_hi         (rd_hi),
    .busy          (x_busy),
    .done          (x_done),
    .cs_n          (pnl_cs_n),
    .rs            (pnl_rs),
    .wr_n          (pnl_wr_n),
    .rd_n          (pnl_rd_n),
    .drv_en        (x_drv),
    .wdata         (x_wdata),
    .cap_en        (x_cap)
  );

  pdm_rst_pulse #(.RW(RSTLEN_W)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (r_start),
    .len       (rst_len),
    .busy      (r_busy),
    .done      (r_done),
    .pnl_rst_n (pnl_rst_n)
  );

  pdm_bus_io #(.DW(DATA_W)) u_io (
    .clk     (clk),
    .rst_n   (rst_n),
    .drv_en  (x_drv),
    .wdata   (x_wdata),
    .cap_en  (x_cap),
    .wr_n    (pnl_wr_n),
    .db      (pnl_db),
    .rd_data (rd_data)
  );

  AST_RESET_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !busy) |=> (!pnl_rst_n && pnl_cs_n)); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pnl_wr_n && !pnl_rd_n)); // R2
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pnl_rst_n && !pnl_cs_n)); // R9
endmodule

// File: tb/tb_parbus_disp_master.sv
`timescale 1ns/1ps
module tb_parbus_disp_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_is_data, req_is_read, rst_req;
  logic [7:0]  req_wdata, rd_data, pnl_val;
  logic [3:0]  wr_lo, wr_hi, rd_lo, rd_hi;
  logic [15:0] rst_len;
  logic        busy, done, pnl_cs_n, pnl_rs, pnl_wr_n, pnl_rd_n, pnl_rst_n;
  tri   [7:0]  pnl_db;

  int errors = 0;
  int checks = 0;
  int cap_cnt = 0;
  logic [7:0] cap_byte;
  logic       cap_rs;
  logic [7:0] last_rd = 8'h00;

  always #5 clk = ~clk;

  // panel model: drives the bus only while the read strobe is low
  assign pnl_db = (!pnl_rd_n) ? pnl_val : 8'bzzzzzzzz;
  always @(posedge pnl_wr_n) begin
    if (rst_n === 1'b1) begin
      cap_byte = pnl_db;
      cap_rs   = pnl_rs;
      cap_cnt  = cap_cnt + 1;
    end
  end

  parbus_disp_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_data(req_is_data),
    .req_is_read(req_is_read), .req_wdata(req_wdata), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .rst_req(rst_req), .rst_len(rst_len),
    .busy(busy), .done(done), .rd_data(rd_data), .pnl_cs_n(pnl_cs_n),
    .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
    .pnl_rst_n(pnl_rst_n), .pnl_db(pnl_db)
  );

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int due_cycle(input int l, input int h);
    return 3 + eff(l) + eff(h);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_quiet(input string req, input int ncyc);
    int bad = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (!pnl_cs_n || done) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic xfer(input bit isd, input bit isr, input logic [7:0] wd,
                      input int l, input int h, input bit chg, input bit poke);
    int n = 1, cslow = 0, wlo = 0, rlo = 0, first_lo = 0, rs_bad = 0, dbad = 0;
    int cap0;
    cap0 = cap_cnt;
    if (isr) begin
      rd_lo = 4'(l); rd_hi = 4'(h);
      wr_lo = 4'($urandom_range(0, 15)); wr_hi = 4'($urandom_range(0, 15));
    end else begin
      wr_lo = 4'(l); wr_hi = 4'(h);
      rd_lo = 4'($urandom_range(0, 15)); rd_hi = 4'($urandom_range(0, 15));
    end
    pnl_val     = 8'($urandom_range(0, 255));
    req_is_data = isd;
    req_is_read = isr;
    req_wdata   = wd;
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 cs high in setup cycle", int'(pnl_cs_n), 1);
    chk("R1 register select value", int'(pnl_rs), int'(isd));
    chk("R7 busy after accept", int'(busy), 1);
    while (!done && n < 100) begin
      if (!pnl_cs_n) cslow++;
      if (!pnl_wr_n) wlo++;
      if (!pnl_rd_n) rlo++;
      if (first_lo == 0 && (!pnl_wr_n || !pnl_rd_n)) first_lo = n;
      if (!pnl_cs_n && pnl_rs != isd) rs_bad++;
      if (!isr && pnl_db !== wd) dbad++;
      if (n == 2 && chg) begin
        wr_lo = ~wr_lo; wr_hi = ~wr_hi; rd_lo = ~rd_lo; rd_hi = ~rd_hi;
      end
      if (n == 2 && poke) req_valid = 1'b1;
      if (n == 3) req_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(chg ? "R6 done cycle with changed timing" : "R7 done cycle", n, due_cycle(l, h));
    chk("R5 cs low cycles", cslow, 1 + eff(l) + eff(h));
    chk("R5 strobe low cycles", isr ? rlo : wlo, eff(l));
    chk("R2 wrong strobe quiet", isr ? wlo : rlo, 0);
    chk("R2 strobe falls third cycle", first_lo, 3);
    chk("R1 register select held", rs_bad, 0);
    chk("R7 cs high at done", int'(pnl_cs_n), 1);
    if (isr) begin
      chk("R4 read byte", int'(rd_data), int'(pnl_val));
      last_rd = pnl_val;
    end else begin
      chk("R3 bus held with write byte", dbad, 0);
      chk("R3 panel latched once", cap_cnt - cap0, 1);
      chk("R3 panel byte", int'(cap_byte), int'(wd));
      chk("R1 panel register select", int'(cap_rs), int'(isd));
      chk("R4 rd_data unchanged by write", int'(rd_data), int'(last_rd));
    end
    @(negedge clk);
    chk("R7 done single pulse", int'(done), 0);
    if (poke) idle_quiet("R8 request while busy dropped", 8);
  endtask

  task automatic rpulse(input int len, input bit with_req);
    int n = 1, low = 0, csl = 0, cap0;
    cap0 = cap_cnt;
    rst_len   = 16'(len);
    rst_req   = 1'b1;
    req_valid = with_req;
    req_is_read = 1'b0;
    req_wdata = 8'hA5;
    @(negedge clk);
    rst_req   = 1'b0;
    req_valid = 1'b0;
    while (!done && n < 1000) begin
      if (!pnl_rst_n) low++;
      if (!pnl_cs_n) csl++;
      chk("R9 busy during reset pulse", int'(busy), 1);
      @(negedge clk);
      n++;
    end
    chk("R9 reset low cycles", low, eff(len));
    chk("R9 release with done", n, eff(len) + 1);
    chk("R9 reset released", int'(pnl_rst_n), 1);
    chk(with_req ? "R10 no transfer alongside reset" : "R9 no transfer", csl, 0);
    if (with_req) begin
      idle_quiet("R10 transfer request dropped", 8);
      chk("R10 panel saw no write", cap_cnt - cap0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog expired: actual 0 expected 1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    req_valid = 0; req_is_data = 0; req_is_read = 0; rst_req = 0;
    req_wdata = 0; wr_lo = 0; wr_hi = 0; rd_lo = 0; rd_hi = 0;
    rst_len = 0; pnl_val = 0;
    repeat (3) @(negedge clk);
    chk("R11 cs_n reset", int'(pnl_cs_n), 1);
    chk("R11 wr_n reset", int'(pnl_wr_n), 1);
    chk("R11 rd_n reset", int'(pnl_rd_n), 1);
    chk("R11 panel reset", int'(pnl_rst_n), 1);
    chk("R11 rs reset", int'(pnl_rs), 1);
    chk("R11 busy/done reset", int'(busy) + int'(done), 0);
    chk("R11 rd_data reset", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    xfer(1'b0, 1'b0, 8'h2C, 1, 1, 1'b0, 1'b0);
    xfer(1'b1, 1'b1, 8'h00, 0, 0, 1'b0, 1'b0);
    xfer(1'b1, 1'b0, 8'hFF, 15, 15, 1'b0, 1'b0);
    xfer(1'b1, 1'b0, 8'h00, 0, 3, 1'b0, 1'b0);
    xfer(1'b0, 1'b1, 8'h11, 5, 2, 1'b1, 1'b0);
    xfer(1'b1, 1'b0, 8'h3C, 2, 4, 1'b1, 1'b0);
    xfer(1'b0, 1'b0, 8'h81, 1, 1, 1'b0, 1'b1);
    xfer(1'b1, 1'b1, 8'h00, 3, 1, 1'b0, 1'b1);
    rpulse(0, 1'b0);
    rpulse(5, 1'b0);
    rpulse(7, 1'b1);
    for (int k = 0; k < 40; k++) begin
      xfer(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 255)), $urandom_range(0, 15),
           $urandom_range(0, 15), 1'($urandom_range(0, 1)), 1'b0);
    end
    rpulse(int'($urandom_range(1, 40)), 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule